// File: doc/BRIEF.md
# Protected MCU Control Register

This block is one byte-wide control register in a small microcontroller. It keeps three settings: where the interrupt vector table starts, whether input pull-ups are forced off across all ports, and whether the on-chip debug port is switched off. The pull-up setting can be written at any time. The other two settings are protected by timed unlock sequences, so a single stray store from runaway code cannot move the vector table or change the debug port.

To move the vector table, software first writes the arm bit. Within the next four cycles it writes the new select value with the arm bit at zero. From the arming write onward, interrupts are held off towards the interrupt controller. If the select value is committed, the hold lasts until one more instruction has completed. If it is not committed, the hold ends when the four-cycle window closes. The debug-off bit only takes a value after the same value has been written twice, with the second write no more than four cycles after the first.

The block also combines the vector placement with two boot-lock inputs and the current execution region to block interrupts. It derives the boot-section base address from a boot-size code.

Top module: `mcu_ctrl_guard`

## Requirements
- R1: After reset, the register reads 0x00, `vec_base` is 0, `pullup_kill` is 0, `irq_block` is 0 when no lock applies, and `dbg_port_en` follows `dbg_fuse_ok`.
- R2: The bit layout is: bit 2 arm, bit 3 vector select, bit 5 pull-up off, bit 6 debug off. Every other bit reads 0, and writes to those bits have no effect.
- R3: A write with bit 2 set makes the arm bit read 1 for exactly four cycles after the write, unless a select write ends the window early.
- R4: A write with bit 2 clear during the arm window loads bit 3 into the vector select and clears the arm bit at once. A write with bit 2 set never changes the vector select.
- R5: A write with bit 2 clear outside an arm window leaves the vector select unchanged, and no error is signalled.
- R6: `irq_block` is high in the same cycle as an arming write and stays high for the whole arm window.
- R7: After a committed select write, `irq_block` stays high up to and including the cycle in which `insn_done` is next high, and falls in the following cycle.
- R8: Bit 6 takes a new value only when that value is written twice, with the second write no more than four cycles after the first.
- R9: A single write to bit 6, a second write after the four-cycle window, or a second write carrying the other value leaves bit 6 unchanged.
- R10: `dbg_port_en` is high exactly when bit 6 is 0 and `dbg_fuse_ok` is high.
- R11: Bit 5 is a plain bit, updated by any write, and `pullup_kill` equals it.
- R12: `vec_base` is 0 when the vector select is 0. Otherwise it is 2^16 − (512 << `boot_size`): 0xFE00, 0xFC00, 0xF800 and 0xF000 for codes 0 to 3.
- R13: `irq_block` is also high when the vector select is 1, `lock_app` is high and `exec_in_boot` is low. It is likewise high when the vector select is 0, `lock_boot` is high and `exec_in_boot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| dbg_fuse_ok | input | 1 | Debug fuse programmed |
| lock_app | input | 1 | Boot lock restricting application-side interrupts |
| lock_boot | input | 1 | Boot lock restricting boot-side interrupts |
| exec_in_boot | input | 1 | CPU currently executes from the boot section |
| boot_size | input | 2 | Boot-section size code |
| insn_done | input | 1 | An instruction completes this cycle |
| vec_base | output | 16 | Vector table base word address |
| pullup_kill | output | 1 | Global pull-up override |
| dbg_port_en | output | 1 | Debug port enable |
| irq_block | output | 1 | Interrupt suppression to the interrupt controller |

## Verification
The hardest cases sit on the boundaries of the four-cycle windows. A select write on the last valid cycle must commit, and the same write one cycle later must be ignored. Both the arm and the debug sequences are therefore driven with idle gaps counted exactly to those edges. Debug sequences also interleave mismatched values, which restart the pending candidate. Release of the interrupt hold depends on an instruction-completion pulse arriving cycles after the commit, so the bench places that pulse explicitly and checks the cycle on both sides of it.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
    // bit positions inside the control byte
    localparam int ARM_B   = 2;
    localparam int VSEL_B  = 3;
    localparam int PUOFF_B = 5;
    localparam int DBG_B   = 6;

    typedef struct packed {
        logic vsel;
        logic hold;
    } vec_st_t;

    typedef struct packed {
        logic dbg_off;
        logic cand;
    } dbg_st_t;
endpackage

// File: rtl/mcg_window.sv
module mcg_window #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic active
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(WIN);
        end else if (stop) begin
            cnt_d = '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

    // R3
    win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));
endmodule

// File: rtl/mcg_vec_guard.sv
module mcg_vec_guard import mcg_pkg::*; #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic arm_bit,
    input  logic sel_bit,
    input  logic insn_done,
    output logic vsel,
    output logic armed,
    output logic mask
);
    vec_st_t st_d, st_q;
    logic    arm_start;
    logic    sel_write;

    assign arm_start = wr_en & arm_bit;
    assign sel_write = wr_en & armed & ~arm_bit;

    mcg_window #(.WIN(WIN)) u_arm_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (arm_start),
        .stop   (sel_write),
        .active (armed)
    );

    always_comb begin
        st_d = st_q;
        if (sel_write) begin
            st_d.vsel = sel_bit;
            st_d.hold = 1'b1;
        end else if (insn_done) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vsel = st_q.vsel;
    assign mask = arm_start | armed | st_q.hold;

    // R5
    vsel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vsel != $past(st_q.vsel)) |-> $past(wr_en && armed && !arm_bit));

    // R7
    hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> $past(insn_done));
endmodule

// File: rtl/mcg_dbg_guard.sv
module mcg_dbg_guard import mcg_pkg::*; #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic dbg_off
);
    dbg_st_t st_d, st_q;
    logic    pending;
    logic    confirm;
    logic    first;

    assign confirm = wr_en & pending & (wr_bit == st_q.cand);
    assign first   = wr_en & ~confirm;

    mcg_window #(.WIN(WIN)) u_pair_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (first),
        .stop   (confirm),
        .active (pending)
    );

    always_comb begin
        st_d = st_q;
        if (confirm) st_d.dbg_off = wr_bit;
        if (first)   st_d.cand    = wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbg_off = st_q.dbg_off;

    // R9
    dbg_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dbg_off != $past(st_q.dbg_off)) |-> $past(wr_en && pending));
endmodule

// File: rtl/mcu_ctrl_guard.sv
module mcu_ctrl_guard import mcg_pkg::*; #(
    parameter int DATA_W        = 8,
    parameter int WIN           = 4,
    parameter int ADDR_W        = 16,
    parameter int BOOT_MIN_LOG2 = 9,
    parameter int BSZ_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dbg_fuse_ok,
    input  logic              lock_app,
    input  logic              lock_boot,
    input  logic              exec_in_boot,
    input  logic [BSZ_W-1:0]  boot_size,
    input  logic              insn_done,
    output logic [ADDR_W-1:0] vec_base,
    output logic              pullup_kill,
    output logic              dbg_port_en,
    output logic              irq_block
);
    localparam logic [DATA_W-1:0] PLAIN_MASK = DATA_W'(1) << PUOFF_B;
    localparam logic [DATA_W-1:0] PROT_MASK  = (DATA_W'(1) << ARM_B) | (DATA_W'(1) << VSEL_B)
                                             | (DATA_W'(1) << DBG_B) | PLAIN_MASK;

    logic [DATA_W-1:0] plain_d, plain_q;
    logic              vsel, armed, vec_mask, dbg_off, lock_hit;
    logic [ADDR_W-1:0] boot_words;

    mcg_vec_guard #(.WIN(WIN)) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .arm_bit   (wr_data[ARM_B]),
        .sel_bit   (wr_data[VSEL_B]),
        .insn_done (insn_done),
        .vsel      (vsel),
        .armed     (armed),
        .mask      (vec_mask)
    );

    mcg_dbg_guard #(.WIN(WIN)) u_dbg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bit  (wr_data[DBG_B]),
        .dbg_off (dbg_off)
    );

    always_comb begin
        plain_d = plain_q;
        if (wr_en) plain_d = wr_data & PLAIN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) plain_q <= '0;
        else        plain_q <= plain_d;
    end

    always_comb begin
        rd_data         = plain_q;
        rd_data[ARM_B]  = armed;
        rd_data[VSEL_B] = vsel;
        rd_data[DBG_B]  = dbg_off;
    end

    always_comb begin
        boot_words = ADDR_W'(1) << (BOOT_MIN_LOG2 + int'(boot_size));
        vec_base   = vsel ? (ADDR_W'(0) - boot_words) : '0;
    end

    assign lock_hit    = (vsel & lock_app & ~exec_in_boot) | (~vsel & lock_boot & exec_in_boot);
    assign irq_block   = vec_mask | lock_hit;
    assign pullup_kill = plain_q[PUOFF_B];
    assign dbg_port_en = ~dbg_off & dbg_fuse_ok;

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~PROT_MASK) == '0);

    // R6
    irq_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[ARM_B]) |-> irq_block);

    // R10
    dbg_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_port_en |-> dbg_fuse_ok);
endmodule

// File: tb/mcu_ctrl_guard_test.sv
`timescale 1ns/1ps
module mcu_ctrl_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        dbg_fuse_ok = 1'b1;
    logic        lock_app = 1'b0;
    logic        lock_boot = 1'b0;
    logic        exec_in_boot = 1'b0;
    logic [1:0]  boot_size = 2'd2;
    logic        insn_done = 1'b0;
    logic [15:0] vec_base;
    logic        pullup_kill, dbg_port_en, irq_block;

    logic       fuse_v = 1'b1, lapp_v = 1'b0, lboot_v = 1'b0, inboot_v = 1'b0;
    logic [1:0] bsz_v = 2'd2;
    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0]  rd;
        logic [15:0] vb;
        logic        pk, de, irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    mcu_ctrl_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .dbg_fuse_ok(dbg_fuse_ok), .lock_app(lock_app), .lock_boot(lock_boot),
        .exec_in_boot(exec_in_boot), .boot_size(boot_size), .insn_done(insn_done),
        .vec_base(vec_base), .pullup_kill(pullup_kill), .dbg_port_en(dbg_port_en),
        .irq_block(irq_block)
    );

    task automatic cyc(input logic w, input logic [7:0] d, input logic ins,
                       input logic [7:0] e_rd, input logic [15:0] e_vb, input logic e_irq,
                       input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = w; wr_data = d; insn_done = ins;
        dbg_fuse_ok = fuse_v; lock_app = lapp_v; lock_boot = lboot_v;
        exec_in_boot = inboot_v; boot_size = bsz_v;
        it.rd = e_rd; it.vb = e_vb; it.irq = e_irq;
        it.pk = e_rd[5]; it.de = !e_rd[6] && fuse_v; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n, input logic [7:0] e_rd, input logic [15:0] e_vb,
                        input logic e_irq, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, e_rd, e_vb, e_irq, tag);
    endtask

    // monitor: compares each cycle mid-way between the negedge and the next posedge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                total++;
                if (rd_data !== it.rd || vec_base !== it.vb || pullup_kill !== it.pk ||
                    dbg_port_en !== it.de || irq_block !== it.irq) begin
                    bad++;
                    $display("FAIL %s: actual rd=%h vb=%h pk=%b de=%b irq=%b expected rd=%h vb=%h pk=%b de=%b irq=%b",
                             it.tag, rd_data, vec_base, pullup_kill, dbg_port_en, irq_block,
                             it.rd, it.vb, it.pk, it.de, it.irq);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R1 reset state");

        // arm then let window expire
        cyc(1, 8'h04, 0, 8'h00, 16'h0, 1, "R6 block in arming cycle");
        idle(4, 8'h04, 16'h0, 1, "R3 R6 arm window");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R3 arm self-clears");

        // select write with no arm
        cyc(1, 8'h08, 0, 8'h00, 16'h0, 0, "R5 unarmed select write");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R5 select unchanged");

        // early commit
        cyc(1, 8'h04, 0, 8'h00, 16'h0, 1, "R6 arm");
        cyc(0, 8'h00, 0, 8'h04, 16'h0, 1, "R3 armed");
        cyc(1, 8'h08, 0, 8'h04, 16'h0, 1, "R4 select write");
        cyc(0, 8'h00, 0, 8'h08, 16'hF800, 1, "R4 commit and arm cleared");
        cyc(0, 8'h00, 0, 8'h08, 16'hF800, 1, "R7 hold");
        cyc(0, 8'h00, 1, 8'h08, 16'hF800, 1, "R7 hold through insn_done");
        cyc(0, 8'h00, 0, 8'h08, 16'hF800, 0, "R7 hold released");

        // commit on last window cycle; arming write keeps select
        cyc(1, 8'h0C, 0, 8'h08, 16'hF800, 1, "R4 arming write");
        idle(3, 8'h0C, 16'hF800, 1, "R4 arming keeps select");
        cyc(1, 8'h00, 0, 8'h0C, 16'hF800, 1, "R4 last window cycle");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 1, "R4 cleared select");
        cyc(0, 8'h00, 1, 8'h00, 16'h0, 1, "R7 hold");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R7 released");

        // write one cycle past window
        cyc(1, 8'h04, 0, 8'h00, 16'h0, 1, "R6 arm");
        idle(4, 8'h04, 16'h0, 1, "R3 window");
        cyc(1, 8'h08, 0, 8'h00, 16'h0, 0, "R5 late select write");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R5 late write ignored");

        // reserved bits
        cyc(1, 8'h93, 0, 8'h00, 16'h0, 0, "R2 reserved write");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R2 reserved read zero");

        // pull-up
        cyc(1, 8'h20, 0, 8'h00, 16'h0, 0, "R11 write");
        cyc(0, 8'h00, 0, 8'h20, 16'h0, 0, "R11 pullup_kill set");
        cyc(1, 8'h00, 0, 8'h20, 16'h0, 0, "R11 write");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R11 pullup_kill clear");

        // debug off, two writes three cycles apart
        cyc(1, 8'h40, 0, 8'h00, 16'h0, 0, "R8 first write");
        idle(2, 8'h00, 16'h0, 0, "R8 single write no effect");
        cyc(1, 8'h40, 0, 8'h00, 16'h0, 0, "R8 second write");
        cyc(0, 8'h00, 0, 8'h40, 16'h0, 0, "R8 R10 committed port off");

        // clear attempt with late second write
        cyc(1, 8'h00, 0, 8'h40, 16'h0, 0, "R9 first write");
        idle(4, 8'h40, 16'h0, 0, "R9 pending");
        cyc(1, 8'h00, 0, 8'h40, 16'h0, 0, "R9 late second write");
        cyc(0, 8'h00, 0, 8'h40, 16'h0, 0, "R9 late write no change");
        cyc(1, 8'h00, 0, 8'h40, 16'h0, 0, "R8 in-window write");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R8 cleared");

        // mismatching values
        cyc(1, 8'h40, 0, 8'h00, 16'h0, 0, "R9 first");
        cyc(1, 8'h00, 0, 8'h00, 16'h0, 0, "R9 mismatch");
        cyc(1, 8'h40, 0, 8'h00, 16'h0, 0, "R9 mismatch");
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R9 no change after mismatches");

        // fuse gating
        fuse_v = 1'b0;
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R10 fuse off");
        fuse_v = 1'b1;
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R10 fuse on");

        // boot base by size code
        cyc(1, 8'h04, 0, 8'h00, 16'h0, 1, "R6 arm");
        cyc(1, 8'h08, 0, 8'h04, 16'h0, 1, "R4 select");
        cyc(0, 8'h00, 1, 8'h08, 16'hF800, 1, "R12 size 2");
        bsz_v = 2'd0;
        cyc(0, 8'h00, 0, 8'h08, 16'hFE00, 0, "R12 size 0");
        bsz_v = 2'd1;
        cyc(0, 8'h00, 0, 8'h08, 16'hFC00, 0, "R12 size 1");
        bsz_v = 2'd3;
        cyc(0, 8'h00, 0, 8'h08, 16'hF000, 0, "R12 size 3");
        bsz_v = 2'd2;

        // lock-based blocking
        lapp_v = 1'b1;
        cyc(0, 8'h00, 0, 8'h08, 16'hF800, 1, "R13 app lock in app");
        inboot_v = 1'b1;
        cyc(0, 8'h00, 0, 8'h08, 16'hF800, 0, "R13 app lock in boot");
        lapp_v = 1'b0; lboot_v = 1'b1;
        cyc(0, 8'h00, 0, 8'h08, 16'hF800, 0, "R13 boot lock vectors in boot");
        lboot_v = 1'b0; inboot_v = 1'b0;
        cyc(1, 8'h04, 0, 8'h08, 16'hF800, 1, "R6 arm");
        cyc(1, 8'h00, 0, 8'h0C, 16'hF800, 1, "R4 select zero");
        cyc(0, 8'h00, 1, 8'h00, 16'h0, 1, "R7 hold");
        lboot_v = 1'b1; inboot_v = 1'b1;
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 1, "R13 boot lock in boot");
        inboot_v = 1'b0;
        cyc(0, 8'h00, 0, 8'h00, 16'h0, 0, "R13 boot lock in app");

        @(negedge clk);
        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule